// File: doc/BRIEF.md
# Frame Sync Protector with Sync Insertion

This block keeps a serial disc-read bit stream aligned to its frame boundaries. It runs one clock per channel bit. An upstream pattern matcher pulses `sync_det` when it sees something that looks like a frame sync. A free-running phase counter predicts where the next boundary should fall. A detected sync counts only if it lands inside a tolerance window around that prediction. Any detection outside the window is treated as noise and dropped.

When a frame passes with no usable detection, the block makes up the boundary from its own counter at the late edge of the window, so downstream logic still sees one frame strobe per frame. After too many of these made-up boundaries in a row, the block declares itself unlocked. In that state it takes the very next detection wherever it falls and then returns to windowed operation.

Two flags report alignment quality. `coin_flag` is set when an accepted sync falls exactly on the predicted position. `lock_flag` is a slow, debounced version of `coin_flag`, driven by an external sampling strobe.

Top module: `frame_sync_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its counters, drives `unlock_flag` high, and drives `lock_flag`, `coin_flag`, `frame_strobe` and `frame_inserted` low.
- R2: `win_sel` sets the window half-width W in channel bits: 0→3, 1→7, 2→13, 3→26. The window spans phase positions FRAME_LEN−W … FRAME_LEN−1 and 0 … W. Phase 0 is the prediction.
- R3: A `sync_det` sampled inside the window is accepted when it is the first one of that window. On the next cycle `frame_strobe` is high and `frame_inserted` is low. The phase counter is realigned so that the accepted bit becomes phase 0, and the next prediction falls FRAME_LEN clocks later.
- R4: A `sync_det` sampled outside the window while `unlock_flag` is low produces no strobe and leaves the phase counter unchanged.
- R5: If no sync was accepted by the clock that samples phase W, `frame_strobe` and `frame_inserted` are both high on the following cycle. An insertion clears `coin_flag`.
- R6: `lim_sel` sets the insertion limit N: 0→2, 1→4, 2→8, 3→13. `unlock_flag` rises together with the strobe of the N-th consecutive insertion.
- R7: Every accepted sync clears the consecutive-insertion count.
- R8: While `unlock_flag` is high, any `sync_det` is accepted regardless of phase. The acceptance drives `unlock_flag` low.
- R9: `coin_flag` is updated only on frame events. It goes high when a sync is accepted at phase 0 and low on any other accepted or inserted frame.
- R10: `lock_flag` is high on the cycle after any cycle in which `coin_flag` is high.
- R11: `lock_flag` falls on the LOCK_SAMPLES-th consecutive `lock_smp` strobe that samples `coin_flag` low (default 8). A strobe that samples `coin_flag` high restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel-bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_det | input | 1 | Candidate sync pulse from the pattern matcher |
| win_sel | input | 2 | Window half-width code |
| lim_sel | input | 2 | Consecutive-insertion limit code |
| lock_smp | input | 1 | Slow sampling strobe for the lock filter |
| frame_strobe | output | 1 | One-cycle pulse per accepted or inserted frame |
| frame_inserted | output | 1 | High together with `frame_strobe` when the frame was inserted |
| coin_flag | output | 1 | Detected sync coincided with the prediction |
| unlock_flag | output | 1 | Insertion limit reached; re-acquiring |
| lock_flag | output | 1 | Debounced coincidence status |

## Verification
The bench builds the block with FRAME_LEN = 96 and LOCK_SAMPLES = 8. The short frame is still wider than twice the largest window (53 bits). That keeps all four window codes exact at both edges and one bit beyond them. It also makes a run of 13 insertions cost only about 1,250 clocks, so the largest limit is exercised in full next to the smallest. With the default sample count, the bench can show that the debounce count restarts: 7 low samples, one high, 7 more low samples, and the lock still holds until the 8th.

// File: rtl/fsg_pkg.sv
// Shared decode helpers for the frame sync protector.
// Assumes code values are the 2-bit register fields described in the brief.
package fsg_pkg;

    // Window half-width in channel bits for a window code.
    function automatic int unsigned win_half(input logic [1:0] code);
        case (code)
            2'd0:    return 3;
            2'd1:    return 7;
            2'd2:    return 13;
            default: return 26;
        endcase
    endfunction

    // Consecutive-insertion limit for a limit code.
    function automatic int unsigned ins_limit(input logic [1:0] code);
        case (code)
            2'd0:    return 2;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 13;
        endcase
    endfunction

    localparam int unsigned MAX_LIMIT = 13;
    localparam int unsigned CNT_W     = $clog2(MAX_LIMIT + 1);

endpackage

// File: rtl/fsg_phase_ctr.sv
// Frame phase counter: counts channel bits modulo FRAME_LEN and decodes
// the acceptance window around phase 0.
// Assumes FRAME_LEN > 2*26+1 so the widest window never overlaps itself.
module fsg_phase_ctr #(
    parameter int unsigned FRAME_LEN = 588,
    localparam int unsigned PW = $clog2(FRAME_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          realign,
    input  logic [1:0]    win_sel,
    output logic          in_win,
    output logic          at_close,
    output logic          at_pred
);
    import fsg_pkg::*;

    localparam logic [PW-1:0] LAST = PW'(FRAME_LEN - 1);
    localparam logic [PW-1:0] LEN  = PW'(FRAME_LEN);

    logic [PW-1:0] pos;
    logic [PW-1:0] half;

    // Half-width of the window selected by the code.
    always_comb half = PW'(win_half(win_sel));

    // Window decode relative to the predicted phase 0.
    always_comb begin
        in_win   = (pos <= half) || (pos >= (LEN - half));
        at_close = (pos == half);
        at_pred  = (pos == '0);
    end

    // Phase advance; an accepted sync becomes phase 0 so the next bit is 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (realign)
            pos <= PW'(1);
        else if (pos == LAST)
            pos <= '0;
        else
            pos <= pos + PW'(1);
    end

endmodule

// File: rtl/fsg_protect.sv
// Protect/insert decision: accepts windowed (or, when unlocked, any)
// detections, inserts a frame at window close, counts consecutive inserts
// against the selected limit and keeps the coincidence flag.
// Assumes at most one close per frame from the phase counter.
module fsg_protect (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_det,
    input  logic [1:0] lim_sel,
    input  logic       in_win,
    input  logic       at_close,
    input  logic       at_pred,
    output logic       realign,
    output logic       frame_strobe,
    output logic       frame_inserted,
    output logic       coin_flag,
    output logic       unlock_flag
);
    import fsg_pkg::*;

    logic             got;
    logic             accept;
    logic             insert;
    logic [CNT_W-1:0] ins_cnt;
    logic [CNT_W-1:0] limit;

    // Limit for the selected code.
    always_comb limit = CNT_W'(ins_limit(lim_sel));

    // Frame event decode for this bit.
    always_comb begin
        accept  = sync_det && (unlock_flag || (in_win && !got));
        insert  = at_close && !got && !accept;
        realign = accept;
    end

    // Strobe outputs, one cycle after the deciding edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_strobe   <= 1'b0;
            frame_inserted <= 1'b0;
        end else begin
            frame_strobe   <= accept || insert;
            frame_inserted <= insert;
        end
    end

    // One acceptance per window: set on accept, cleared at window close.
    always_ff @(posedge clk) begin
        if (!rst_n)
            got <= 1'b0;
        else if (accept)
            got <= 1'b1;
        else if (at_close)
            got <= 1'b0;
    end

    // Consecutive insert counter and unlock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_cnt     <= '0;
            unlock_flag <= 1'b1;
        end else if (accept) begin
            ins_cnt     <= '0;
            unlock_flag <= 1'b0;
        end else if (insert) begin
            if (ins_cnt < limit)
                ins_cnt <= ins_cnt + CNT_W'(1);
            if ((ins_cnt + CNT_W'(1)) >= limit)
                unlock_flag <= 1'b1;
        end
    end

    // Coincidence flag, refreshed on each frame event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            coin_flag <= 1'b0;
        else if (accept)
            coin_flag <= at_pred;
        else if (insert)
            coin_flag <= 1'b0;
    end

endmodule

// File: rtl/fsg_lock_filter.sv
// Lock debounce: rises the cycle after coincidence is seen, falls only after
// LOCK_SAMPLES consecutive sampling strobes find coincidence low.
// Assumes lock_smp is a one-cycle strobe.
module fsg_lock_filter #(
    parameter int unsigned LOCK_SAMPLES = 8,
    localparam int unsigned LW = $clog2(LOCK_SAMPLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic coin_flag,
    input  logic lock_smp,
    output logic lock_flag
);
    localparam logic [LW-1:0] LAST = LW'(LOCK_SAMPLES - 1);

    logic [LW-1:0] low_cnt;

    // Fast rise, counted fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_flag <= 1'b0;
            low_cnt   <= '0;
        end else if (coin_flag) begin
            lock_flag <= 1'b1;
            if (lock_smp)
                low_cnt <= '0;
        end else if (lock_smp) begin
            if (low_cnt == LAST) begin
                lock_flag <= 1'b0;
                low_cnt   <= '0;
            end else begin
                low_cnt <= low_cnt + LW'(1);
            end
        end
    end

endmodule

// File: rtl/frame_sync_guard.sv
// Top: frame sync protection with windowed acceptance, insertion from the
// internal phase counter, unlock after a run of insertions, and a debounced
// lock flag. One clock per channel bit.
module frame_sync_guard #(
    parameter int unsigned FRAME_LEN    = 588,
    parameter int unsigned LOCK_SAMPLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_det,
    input  logic [1:0] win_sel,
    input  logic [1:0] lim_sel,
    input  logic       lock_smp,
    output logic       frame_strobe,
    output logic       frame_inserted,
    output logic       coin_flag,
    output logic       unlock_flag,
    output logic       lock_flag
);
    logic realign;
    logic in_win;
    logic at_close;
    logic at_pred;

    fsg_phase_ctr #(.FRAME_LEN(FRAME_LEN)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .realign  (realign),
        .win_sel  (win_sel),
        .in_win   (in_win),
        .at_close (at_close),
        .at_pred  (at_pred)
    );

    fsg_protect u_protect (
        .clk            (clk),
        .rst_n          (rst_n),
        .sync_det       (sync_det),
        .lim_sel        (lim_sel),
        .in_win         (in_win),
        .at_close       (at_close),
        .at_pred        (at_pred),
        .realign        (realign),
        .frame_strobe   (frame_strobe),
        .frame_inserted (frame_inserted),
        .coin_flag      (coin_flag),
        .unlock_flag    (unlock_flag)
    );

    fsg_lock_filter #(.LOCK_SAMPLES(LOCK_SAMPLES)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .coin_flag (coin_flag),
        .lock_smp  (lock_smp),
        .lock_flag (lock_flag)
    );

endmodule

// File: rtl/frame_sync_guard_chk.sv
// Port-level temporal checks for frame_sync_guard, attached by bind.
module frame_sync_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic lock_smp,
    input logic frame_strobe,
    input logic frame_inserted,
    input logic coin_flag,
    input logic unlock_flag,
    input logic lock_flag
);
    logic was_rst;

    // Remember that the previous edge saw reset asserted.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1: one edge after reset the outputs show the reset state.
    always_ff @(posedge clk) begin
        if (was_rst === 1'b1)
            a_r1_reset_state: assert (unlock_flag && !lock_flag && !frame_strobe
                                      && !frame_inserted && !coin_flag);
    end

    // R5: an inserted frame always carries a strobe.
    a_r5_insert_strobed: assert property (@(posedge clk) disable iff (!rst_n)
        frame_inserted |-> frame_strobe);

    // R6: unlock rises only together with an inserted frame.
    a_r6_unlock_on_insert: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock_flag) |-> (frame_strobe && frame_inserted));

    // R8: unlock clears only with an accepted frame.
    a_r8_relock_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unlock_flag) |-> (frame_strobe && !frame_inserted));

    // R9: coincidence rises only with an accepted frame.
    a_r9_coin_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coin_flag) |-> (frame_strobe && !frame_inserted));

    // R10: coincidence forces lock on the next cycle.
    a_r10_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
        coin_flag |=> lock_flag);

    // R11: lock falls only on a sampling strobe with coincidence low.
    a_r11_lock_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_flag) |-> ($past(lock_smp) && !$past(coin_flag)));

endmodule

bind frame_sync_guard frame_sync_guard_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lock_smp       (lock_smp),
    .frame_strobe   (frame_strobe),
    .frame_inserted (frame_inserted),
    .coin_flag      (coin_flag),
    .unlock_flag    (unlock_flag),
    .lock_flag      (lock_flag)
);

// File: tb/frame_sync_guard_tb.sv
`timescale 1ns/1ps
module frame_sync_guard_tb;

    localparam int L = 96;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_det = 1'b0;
    logic [1:0] win_sel = 2'd0;
    logic [1:0] lim_sel = 2'd3;
    logic       lock_smp = 1'b0;
    logic       frame_strobe, frame_inserted, coin_flag, unlock_flag, lock_flag;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    frame_sync_guard #(.FRAME_LEN(L), .LOCK_SAMPLES(8)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sync_det       (sync_det),
        .win_sel        (win_sel),
        .lim_sel        (lim_sel),
        .lock_smp       (lock_smp),
        .frame_strobe   (frame_strobe),
        .frame_inserted (frame_inserted),
        .coin_flag      (coin_flag),
        .unlock_flag    (unlock_flag),
        .lock_flag      (lock_flag)
    );

    function automatic int wh(input int code);
        case (code)
            0: return 3;
            1: return 7;
            2: return 13;
            default: return 26;
        endcase
    endfunction

    function automatic int lim(input int code);
        case (code)
            0: return 2;
            1: return 4;
            2: return 8;
            default: return 13;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sync_det = 1'b0; lock_smp = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Pulse sync so it is sampled gap edges after the last observed edge.
    task automatic pulse_gap(input int gap);
        repeat (gap - 1) @(negedge clk);
        sync_det = 1'b1;
        @(negedge clk);
        sync_det = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 unlock", int'(unlock_flag), 1);
        chk("R1 lock", int'(lock_flag), 0);
        chk("R1 strobe", int'(frame_strobe), 0);
        chk("R1 coin", int'(coin_flag), 0);
    endtask

    task automatic t_window(input int code);
        int w;
        w = wh(code);
        do_reset();
        win_sel = 2'(code); lim_sel = 2'd3;
        pulse_gap(5);
        chk("R8 acquire strobe", int'(frame_strobe), 1);
        chk("R8 acquire unlock", int'(unlock_flag), 0);
        pulse_gap(L + w);                        // late window edge
        chk("R2 late edge strobe", int'(frame_strobe), 1);
        chk("R3 late edge not inserted", int'(frame_inserted), 0);
        chk("R9 off-centre coin", int'(coin_flag), 0);
        pulse_gap(L - w);                        // early window edge
        chk("R2 early edge strobe", int'(frame_strobe), 1);
        chk("R3 early edge not inserted", int'(frame_inserted), 0);
        pulse_gap(L - w - 1);                    // one bit before window
        chk("R4 early outside", int'(frame_strobe), 0);
        idle(2 * w + 1);                         // window close
        chk("R5 insert strobe", int'(frame_strobe), 1);
        chk("R5 insert flag", int'(frame_inserted), 1);
        chk("R9 coin after insert", int'(coin_flag), 0);
        pulse_gap(1);                            // one bit after window
        chk("R4 late outside", int'(frame_strobe), 0);
        pulse_gap(L - w - 1);                    // exact prediction
        chk("R9 coincidence", int'(coin_flag), 1);
        chk("R3 centre not inserted", int'(frame_inserted), 0);
    endtask

    task automatic t_limit(input int code);
        int n;
        n = lim(code);
        do_reset();
        win_sel = 2'd0; lim_sel = 2'(code);
        pulse_gap(5);
        for (int i = 1; i <= n; i++) begin
            idle(i == 1 ? L + 3 : L);
            chk("R5 repeated insert", int'(frame_inserted), 1);
            chk("R6 unlock vs count", int'(unlock_flag), (i >= n) ? 1 : 0);
        end
        pulse_gap(17);
        chk("R8 any phase accept", int'(frame_strobe), 1);
        chk("R8 unlock cleared", int'(unlock_flag), 0);
    endtask

    task automatic t_clear();
        do_reset();
        win_sel = 2'd0; lim_sel = 2'd0;
        pulse_gap(5);
        idle(L + 3);
        chk("R6 first insert keeps lock", int'(unlock_flag), 0);
        pulse_gap(L - 3);
        chk("R3 accepted between inserts", int'(frame_strobe), 1);
        idle(L + 3);
        chk("R7 count cleared", int'(unlock_flag), 0);
        idle(L);
        chk("R6 second consecutive insert", int'(unlock_flag), 1);
    endtask

    task automatic t_lock();
        do_reset();
        win_sel = 2'd0; lim_sel = 2'd3;
        pulse_gap(5);
        pulse_gap(L);
        chk("R9 coin set", int'(coin_flag), 1);
        idle(1);
        chk("R10 lock rise", int'(lock_flag), 1);
        idle(L + 2);
        chk("R9 coin cleared", int'(coin_flag), 0);
        lock_smp = 1'b1; idle(7); lock_smp = 1'b0;
        chk("R11 seven lows hold", int'(lock_flag), 1);
        pulse_gap(L - 10);
        chk("R9 coin again", int'(coin_flag), 1);
        lock_smp = 1'b1; idle(1); lock_smp = 1'b0;
        idle(L + 2);
        chk("R9 coin cleared again", int'(coin_flag), 0);
        lock_smp = 1'b1; idle(7);
        chk("R11 count restarted", int'(lock_flag), 1);
        idle(1); lock_smp = 1'b0;
        chk("R11 eighth low drops", int'(lock_flag), 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        t_reset();
        for (int c = 0; c < 4; c++) t_window(c);
        t_limit(0);
        t_limit(3);
        t_clear();
        t_lock();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
        $finish;
    end

endmodule